// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the raster timing for a TFT display. It divides the host clock by an even ratio to make the pixel clock. It then walks each scan line through four horizontal phases and each frame through four vertical phases, driving horizontal sync, vertical sync and a data-enable strobe. Each of the three outputs has its own polarity control. The current horizontal and vertical phases are presented as two-bit status codes. A line counter runs down over the visible lines. While data-enable is asserted, pixel column and row coordinates are given to a downstream fetch unit.

Timing is set through a small write-only configuration port that fills a shadow copy of the settings. The working copy is refreshed from the shadow only at a frame boundary, or continuously while the block is disabled, so the current frame is never disturbed by a write. A separate enable input starts the timing. Dropping the enable input returns every counter to its start point and parks the outputs at their inactive levels.

Top module: `tft_sync_gen`

## Requirements
- R1: The pixel clock has a period of 2*(K+1) host clocks, where K is the 10-bit divider field, except that a field value of 0 is treated as K=1. The pixel clock is low while the block is disabled, and its first rising edge comes K+1 enabled host cycles after enable.
- R2: The edge-select bit (configuration word 0, bit 16) sets the panel sampling edge: 1 means rising, 0 means falling. All timing state advances only on the pixel-clock transition away from the sampling level, so that outputs are stable at the sampling edge.
- R3: Each line consists of sync for (HS+1) pixel clocks, then back porch for (HB+1), then active for (HA+1), then front porch for (HF+1), after which the next line begins.
- R4: Each frame consists of sync for (VS+1) lines, then back porch for (VB+1) lines, then active for (VA+1) lines, then front porch for (VF+1) lines, after which the next frame begins.
- R5: The horizontal and vertical status outputs use these codes: 00 for sync, 01 for back porch, 10 for active, 11 for front porch.
- R6: The line counter shows VA on the first active line and falls by one on each later active line, reaching 0 on the last one. It reads 0 outside the active lines.
- R7: Invert bits for horizontal sync (word 0, bit 17), vertical sync (bit 18) and data enable (bit 19) are XORed onto the active-high sync signals and onto the data-enable signal.
- R8: Data enable is active only when both phases are active and the block is running. During the active region, pixel column = position within the active pixels (0..HA) and row = position within the active lines (0..VA); both read 0 elsewhere.
- R9: While enable is low, the pixel clock is held low, both phases read sync, the line counter reads 0, and all three outputs sit at their inactive levels under the current polarity bits. This also holds after reset, when every field is 0.
- R10: A configuration write during a running frame has no effect on timing, polarity or divider until the next frame starts. While disabled, a write takes effect one cycle later.
- R11: Configuration words are laid out as follows. Word 0: divider in [9:0], edge in bit 16, inverts in [19:17]. Word 1: HS in [7:0], HF in [15:8], HB in [22:16]. Word 2: HA in [10:0]. Word 3: VS in [5:0], VB in [15:8], VF in [23:16]. Word 4: VA in [9:0]. Writes to words 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timing and video enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| hphase_o | output | 2 | Horizontal phase code |
| vphase_o | output | 2 | Vertical phase code |
| line_cnt_o | output | 10 | Down-counting active line counter |
| pix_x_o | output | 11 | Active pixel column |
| pix_y_o | output | 10 | Active row |

## Verification
The properties assume that enable and configuration writes are synchronous to the host clock. They place no limit on the field values, because phase ordering and the pixel-clock minimum width must hold for any setting, including divider 0 and all-zero lengths. The stimulus keeps every input change on the falling clock edge. It uses small random field values so that several whole frames fit in the run, and it adds directed cases for maximum horizontal fields, writes in the middle of a frame, unused word indices, and dropping enable in the middle of a frame.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;
  // field widths
  localparam int CLKV_W = 10;
  localparam int HSW_W  = 8;
  localparam int HBP_W  = 7;
  localparam int HFP_W  = 8;
  localparam int HACT_W = 11;
  localparam int VSW_W  = 6;
  localparam int VBP_W  = 8;
  localparam int VFP_W  = 8;
  localparam int VACT_W = 10;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;

  // configuration word indices
  localparam logic [ADDR_W-1:0] W_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] W_HTIM = 3'd1;
  localparam logic [ADDR_W-1:0] W_HACT = 3'd2;
  localparam logic [ADDR_W-1:0] W_VTIM = 3'd3;
  localparam logic [ADDR_W-1:0] W_VACT = 3'd4;

  // bit positions inside the words
  localparam int B_EDGE   = 16;
  localparam int B_INV_HS = 17;
  localparam int B_INV_VS = 18;
  localparam int B_INV_DE = 19;
  localparam int HFP_LSB  = 8;
  localparam int HBP_LSB  = 16;
  localparam int VBP_LSB  = 8;
  localparam int VFP_LSB  = 16;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'b00,
    PH_BACK  = 2'b01,
    PH_ACT   = 2'b10,
    PH_FRONT = 2'b11
  } phase_e;

  typedef struct packed {
    logic [CLKV_W-1:0] clkval;
    logic              edge_rise;
    logic              inv_hs;
    logic              inv_vs;
    logic              inv_de;
    logic [HSW_W-1:0]  hsw;
    logic [HBP_W-1:0]  hbp;
    logic [HACT_W-1:0] hact;
    logic [HFP_W-1:0]  hfp;
    logic [VSW_W-1:0]  vsw;
    logic [VBP_W-1:0]  vbp;
    logic [VACT_W-1:0] vact;
    logic [VFP_W-1:0]  vfp;
  } tcfg_t;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/tsg_cfg_regs.sv
module tsg_cfg_regs
  import tft_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              frame_wrap,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output tcfg_t             cfg_act,
  output tcfg_t             cfg_load
);
  tcfg_t shadow_q, shadow_d;
  tcfg_t act_q, act_d;
  logic  reload;
  logic  unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    shadow_d = shadow_q;
    unique case (addr)
      W_CTRL: begin
        shadow_d.clkval    = wdata[CLKV_W-1:0];
        shadow_d.edge_rise = wdata[B_EDGE];
        shadow_d.inv_hs    = wdata[B_INV_HS];
        shadow_d.inv_vs    = wdata[B_INV_VS];
        shadow_d.inv_de    = wdata[B_INV_DE];
      end
      W_HTIM: begin
        shadow_d.hsw = wdata[HSW_W-1:0];
        shadow_d.hfp = wdata[HFP_LSB +: HFP_W];
        shadow_d.hbp = wdata[HBP_LSB +: HBP_W];
      end
      W_HACT: shadow_d.hact = wdata[HACT_W-1:0];
      W_VTIM: begin
        shadow_d.vsw = wdata[VSW_W-1:0];
        shadow_d.vbp = wdata[VBP_LSB +: VBP_W];
        shadow_d.vfp = wdata[VFP_LSB +: VFP_W];
      end
      W_VACT: shadow_d.vact = wdata[VACT_W-1:0];
      default: ;
    endcase
  end

  // working copy follows the shadow only between frames or while idle
  assign reload   = !en || frame_wrap;
  assign act_d    = reload ? shadow_q : act_q;
  assign cfg_load = act_d;
  assign cfg_act  = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (we) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (reload) begin
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/tsg_pclk_div.sv
module tsg_pclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             edge_rise,
  output logic             pclk,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             pclk_q, pclk_d;
  logic             hit;

  assign lim  = (div_val == '0) ? DIV_W'(1) : div_val;
  assign hit  = (cnt_q == lim);
  // advance on the transition leaving the sampling level
  assign tick = en && hit && (pclk_q == edge_rise);
  assign pclk = pclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    pclk_d = pclk_q;
    if (!en) begin
      cnt_d  = '0;
      pclk_d = 1'b0;
    end else if (hit) begin
      cnt_d  = '0;
      pclk_d = ~pclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end
endmodule

// File: rtl/tsg_phase_ctr.sv
module tsg_phase_ctr
  import tft_sync_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    ph_inc;
  logic          last;

  assign last   = (cnt_q == '0);
  assign ph_inc = ph_q + 2'd1;
  assign wrap   = en && step && last && (ph_q == PH_FRONT);
  assign phase  = ph_q;
  assign cnt    = cnt_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = PH_SYNC;
      cnt_d = len_sync;
    end else if (step) begin
      if (last) begin
        ph_d = phase_e'(ph_inc);
        unique case (ph_d)
          PH_SYNC:  cnt_d = len_sync;
          PH_BACK:  cnt_d = len_back;
          PH_ACT:   cnt_d = len_act;
          PH_FRONT: cnt_d = len_front;
          default:  cnt_d = len_sync;
        endcase
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else if (!en || step) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
  import tft_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BUS_W-1:0]  cfg_wdata,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [1:0]        hphase_o,
  output logic [1:0]        vphase_o,
  output logic [VACT_W-1:0] line_cnt_o,
  output logic [HACT_W-1:0] pix_x_o,
  output logic [VACT_W-1:0] pix_y_o
);
  localparam int HC_W = max4(HSW_W, HBP_W, HACT_W, HFP_W);
  localparam int VC_W = max4(VSW_W, VBP_W, VACT_W, VFP_W);

  tcfg_t         cfg_act, cfg_load;
  logic          tick, h_wrap, frame_wrap;
  phase_e        h_ph, v_ph;
  logic [HC_W-1:0] h_cnt;
  logic [VC_W-1:0] v_cnt;
  logic          run_q;
  logic          h_in_act, v_in_act, de_raw;
  logic          unused_cfg;

  tsg_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .frame_wrap (frame_wrap),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .cfg_act    (cfg_act),
    .cfg_load   (cfg_load)
  );

  tsg_pclk_div #(.DIV_W(CLKV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .div_val   (cfg_act.clkval),
    .edge_rise (cfg_act.edge_rise),
    .pclk      (pclk_o),
    .tick      (tick)
  );

  tsg_phase_ctr #(.CW(HC_W)) u_hctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .step      (tick),
    .len_sync  (HC_W'(cfg_load.hsw)),
    .len_back  (HC_W'(cfg_load.hbp)),
    .len_act   (HC_W'(cfg_load.hact)),
    .len_front (HC_W'(cfg_load.hfp)),
    .phase     (h_ph),
    .cnt       (h_cnt),
    .wrap      (h_wrap)
  );

  tsg_phase_ctr #(.CW(VC_W)) u_vctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .step      (h_wrap),
    .len_sync  (VC_W'(cfg_load.vsw)),
    .len_back  (VC_W'(cfg_load.vbp)),
    .len_act   (VC_W'(cfg_load.vact)),
    .len_front (VC_W'(cfg_load.vfp)),
    .phase     (v_ph),
    .cnt       (v_cnt),
    .wrap      (frame_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  assign unused_cfg = ^{cfg_act.hsw, cfg_act.hbp, cfg_act.hfp, cfg_act.vsw,
                        cfg_act.vbp, cfg_act.vfp, cfg_load.clkval,
                        cfg_load.edge_rise, cfg_load.inv_hs, cfg_load.inv_vs,
                        cfg_load.inv_de};

  assign h_in_act = (h_ph == PH_ACT);
  assign v_in_act = (v_ph == PH_ACT);
  assign de_raw   = run_q && h_in_act && v_in_act;

  assign hsync_o  = (run_q && (h_ph == PH_SYNC)) ^ cfg_act.inv_hs;
  assign vsync_o  = (run_q && (v_ph == PH_SYNC)) ^ cfg_act.inv_vs;
  assign de_o     = de_raw ^ cfg_act.inv_de;
  assign hphase_o = h_ph;
  assign vphase_o = v_ph;

  assign line_cnt_o = v_in_act ? v_cnt[VACT_W-1:0] : '0;
  assign pix_x_o    = (h_in_act && v_in_act) ? (cfg_act.hact - h_cnt[HACT_W-1:0]) : '0;
  assign pix_y_o    = (h_in_act && v_in_act) ? (cfg_act.vact - v_cnt[VACT_W-1:0]) : '0;
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] hph,
  input logic [1:0] vph,
  input logic [9:0] line_cnt,
  input logic       pclk
);
  // R3 / R5: horizontal phase only ever steps forward by one code
  a_r3_hphase_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && hph != $past(hph)) |-> hph == $past(hph) + 2'd1);

  // R4 / R5: vertical phase only ever steps forward by one code
  a_r4_vphase_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && vph != $past(vph)) |-> vph == $past(vph) + 2'd1);

  // R6: line counter moves down by one inside the active lines
  a_r6_linecnt_down: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && vph == 2'b10 && $past(vph) == 2'b10 && line_cnt != $past(line_cnt))
    |-> line_cnt == $past(line_cnt) - 10'd1);

  // R9: disabled state parks both phases at sync and the clock low
  a_r9_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (hph == 2'b00 && vph == 2'b00 && !pclk && line_cnt == 10'd0));

  // R1: divider never goes below one, so each level lasts two cycles or more
  a_r1_pclk_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pclk) && en) |=> pclk);

  a_r1_pclk_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk) |=> !pclk);
endmodule

bind tft_sync_gen tsg_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .hph      (hphase_o),
  .vph      (vphase_o),
  .line_cnt (line_cnt_o),
  .pclk     (pclk_o)
);

// File: tb/tft_sync_gen_tb.sv
`timescale 1ns/1ps
module tft_sync_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n, en, cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        pclk_o, hsync_o, vsync_o, de_o;
  logic [1:0]  hphase_o, vphase_o;
  logic [9:0]  line_cnt_o, pix_y_o;
  logic [10:0] pix_x_o;

  always #2.5 clk = ~clk;

  tft_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .hphase_o(hphase_o), .vphase_o(vphase_o), .line_cnt_o(line_cnt_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
  );

  typedef struct {
    int clkv; int edg; int ihs; int ivs; int ide;
    int hsw; int hbp; int hact; int hfp;
    int vsw; int vbp; int vact; int vfp;
  } mcfg_t;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_on = 0;
  string scen = "init";

  // ---------------- reference model -----------------
  mcfg_t m_sh, m_act;
  int    m_div, m_pclk, m_run, m_px, m_ln;

  function automatic int kval(int c); return (c == 0) ? 1 : c; endfunction
  function automatic int hsum(mcfg_t c); return c.hsw + c.hbp + c.hact + c.hfp + 4; endfunction
  function automatic int vsum(mcfg_t c); return c.vsw + c.vbp + c.vact + c.vfp + 4; endfunction
  function automatic int flen(mcfg_t c); return 2 * (kval(c.clkv) + 1) * hsum(c) * vsum(c); endfunction
  function automatic int seg(int p, int a, int b, int c);
    if (p < a + 1)         return 0;
    if (p < a + b + 2)     return 1;
    if (p < a + b + c + 3) return 2;
    return 3;
  endfunction
  function automatic mcfg_t apply_wr(mcfg_t s, int a, logic [31:0] d);
    mcfg_t r = s;
    case (a)
      0: begin r.clkv = int'(d[9:0]); r.edg = int'(d[16]); r.ihs = int'(d[17]);
               r.ivs = int'(d[18]); r.ide = int'(d[19]); end
      1: begin r.hsw = int'(d[7:0]); r.hfp = int'(d[15:8]); r.hbp = int'(d[22:16]); end
      2: r.hact = int'(d[10:0]);
      3: begin r.vsw = int'(d[5:0]); r.vbp = int'(d[15:8]); r.vfp = int'(d[23:16]); end
      4: r.vact = int'(d[9:0]);
      default: ;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin : model
    mcfg_t old;
    int    k;
    bit    tk;
    if (!rst_n) begin
      m_sh = '{default:0}; m_act = '{default:0};
      m_div = 0; m_pclk = 0; m_run = 0; m_px = 0; m_ln = 0;
    end else begin
      old = m_sh;
      if (!en) begin
        m_div = 0; m_pclk = 0; m_px = 0; m_ln = 0; m_act = old;
      end else begin
        k  = kval(m_act.clkv);
        tk = (m_div == k) && (m_pclk == m_act.edg);
        if (m_div == k) begin m_div = 0; m_pclk = 1 - m_pclk; end
        else m_div = m_div + 1;
        if (tk) begin
          if (m_px == hsum(m_act) - 1) begin
            m_px = 0;
            if (m_ln == vsum(m_act) - 1) begin m_ln = 0; m_act = old; end
            else m_ln = m_ln + 1;
          end else m_px = m_px + 1;
        end
      end
      m_run = int'(en);
      if (cfg_we) m_sh = apply_wr(m_sh, int'(cfg_addr), cfg_wdata);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scen, act, exp);
    end
  endtask

  task automatic compare_all();
    int hp, vp, hst, vst, dr;
    hp  = seg(m_px, m_act.hsw, m_act.hbp, m_act.hact);
    vp  = seg(m_ln, m_act.vsw, m_act.vbp, m_act.vact);
    hst = m_act.hsw + m_act.hbp + 2;
    vst = m_act.vsw + m_act.vbp + 2;
    dr  = (m_run == 1 && hp == 2 && vp == 2) ? 1 : 0;
    chk("R1 pclk", int'(pclk_o), m_pclk);
    chk("R2/R3/R5 hphase", int'(hphase_o), hp);
    chk("R4/R5 vphase", int'(vphase_o), vp);
    chk("R2/R7 hsync", int'(hsync_o), ((m_run == 1 && hp == 0) ? 1 : 0) ^ m_act.ihs);
    chk("R7 vsync", int'(vsync_o), ((m_run == 1 && vp == 0) ? 1 : 0) ^ m_act.ivs);
    chk("R8 de", int'(de_o), dr ^ m_act.ide);
    chk("R6 line_cnt", int'(line_cnt_o), (vp == 2) ? m_act.vact - (m_ln - vst) : 0);
    chk("R8 pix_x", int'(pix_x_o), (hp == 2 && vp == 2) ? m_px - hst : 0);
    chk("R8 pix_y", int'(pix_y_o), (hp == 2 && vp == 2) ? m_ln - vst : 0);
  endtask

  always @(negedge clk) if (cmp_on) compare_all();

  // ---------------- stimulus helpers -----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_cfg(mcfg_t c);
    wr(0, {12'd0, 1'(c.ide), 1'(c.ivs), 1'(c.ihs), 1'(c.edg), 6'd0, 10'(c.clkv)});
    wr(1, {9'd0, 7'(c.hbp), 8'(c.hfp), 8'(c.hsw)});
    wr(2, {21'd0, 11'(c.hact)});
    wr(3, {8'd0, 8'(c.vfp), 8'(c.vbp), 2'd0, 6'(c.vsw)});
    wr(4, {22'd0, 10'(c.vact)});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_period(output int p);
    p = 0;
    while (pclk_o !== 1'b1) @(negedge clk);
    while (pclk_o !== 1'b0) begin @(negedge clk); p++; end
    while (pclk_o !== 1'b1) begin @(negedge clk); p++; end
  endtask

  // ---------------- watchdog -----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=190000 expected=finish_earlier");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence -----------------
  initial begin
    mcfg_t c, prev;
    int    per;
    void'($urandom(32'd7715));
    rst_n = 1'b0; en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    idle(4);
    // R9: reset state with all fields zero
    chk("R9 reset pclk", int'(pclk_o), 0);
    chk("R9 reset hsync", int'(hsync_o), 0);
    chk("R9 reset vsync", int'(vsync_o), 0);
    chk("R9 reset de", int'(de_o), 0);
    chk("R9 reset phases", int'({hphase_o, vphase_o}), 0);
    chk("R9 reset line_cnt", int'(line_cnt_o), 0);
    @(negedge clk); rst_n = 1'b1;
    cmp_on = 1;

    // R1 clamp of divider 0, edge rising, small frame
    scen = "R1 clamp";
    c = '{clkv:0, edg:1, ihs:0, ivs:0, ide:0, hsw:1, hbp:0, hact:2, hfp:0,
          vsw:0, vbp:0, vact:1, vfp:0};
    load_cfg(c);
    idle(2);
    en = 1'b1;
    measure_period(per);
    chk("R1 period clamp", per, 4);
    idle(2 * flen(c));

    // R2 falling-edge sampling plus R7 inverts
    scen = "R2 falling edge";
    en = 1'b0;
    c = '{clkv:3, edg:0, ihs:1, ivs:1, ide:1, hsw:0, hbp:1, hact:3, hfp:1,
          vsw:1, vbp:0, vact:2, vfp:1};
    load_cfg(c);
    idle(3);
    // R9: disabled outputs rest at inverted inactive levels
    chk("R9 off hsync", int'(hsync_o), 1);
    chk("R9 off vsync", int'(vsync_o), 1);
    chk("R9 off de", int'(de_o), 1);
    en = 1'b1;
    measure_period(per);
    chk("R1 period k3", per, 8);
    idle(2 * flen(c));
    prev = c;

    // R10: mid-frame rewrite only lands at the next frame
    scen = "R10 midframe";
    idle(flen(prev) / 3);
    c = prev; c.hsw = 4; c.vact = 3; c.clkv = 2; c.ihs = 0;
    load_cfg(c);
    idle(flen(prev) + 2 * flen(c));
    prev = c;

    // R11: unused word indices change nothing
    scen = "R11 unused words";
    wr(5, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'h00FF_00FF);
    idle(flen(prev) + 10);

    // R9: drop enable mid-frame, restart
    scen = "R9 drop enable";
    idle(flen(prev) / 2);
    en = 1'b0;
    idle(3);
    chk("R9 drop pclk", int'(pclk_o), 0);
    chk("R9 drop phases", int'({hphase_o, vphase_o}), 0);
    chk("R9 drop line_cnt", int'(line_cnt_o), 0);
    en = 1'b1;
    idle(flen(prev) + 10);

    // R3: widest horizontal fields
    scen = "R3 wide fields";
    c = '{clkv:1, edg:1, ihs:0, ivs:1, ide:0, hsw:255, hbp:127, hact:3, hfp:255,
          vsw:0, vbp:0, vact:0, vfp:0};
    load_cfg(c);
    idle(flen(prev) + flen(c) + 20);
    prev = c;

    // random configurations
    for (int i = 0; i < 8; i++) begin
      mcfg_t r;
      int    mid;
      scen = $sformatf("rand %0d", i);
      r.clkv = $urandom_range(0, 3); r.edg = $urandom_range(0, 1);
      r.ihs = $urandom_range(0, 1); r.ivs = $urandom_range(0, 1); r.ide = $urandom_range(0, 1);
      r.hsw = $urandom_range(0, 3); r.hbp = $urandom_range(0, 3);
      r.hact = $urandom_range(0, 15); r.hfp = $urandom_range(0, 3);
      r.vsw = $urandom_range(0, 2); r.vbp = $urandom_range(0, 2);
      r.vact = $urandom_range(0, 7); r.vfp = $urandom_range(0, 2);
      mid = $urandom_range(0, 1);
      if (mid == 0) begin en = 1'b0; idle(3); end
      load_cfg(r);
      if (mid == 0) en = 1'b1;
      idle(((mid == 1) ? flen(prev) : 0) + 2 * flen(r) + 20);
      prev = r;
    end

    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule